// File: doc/BRIEF.md
# SCL Divider Search Engine

This block picks the two prescaler settings of a serial clock generator. From an input clock frequency and a wanted bus clock frequency it finds a coarse divider value and a fine divider value such that the bus clock, `Fin / (22 * (A+1) * (B+1))` rounded down, is as close as possible to the target without going above it. Both frequencies are 32-bit unsigned integers in hertz.

A single pulse on `start` launches a search. The engine first checks that the requested ratio can be reached at all. It then tries each coarse value in turn. For each one it derives the smallest fine divider that does not overshoot the target, and it keeps the best candidate. All quotients come from one shared sequential divider, so a search takes a few hundred cycles. When the search ends, `done` pulses and the result stays on the outputs until the next search completes. Writing the result into a control register is left to the surrounding logic.

Top module: `scl_div_search`

## Requirements
- R1: After reset, `div_a`, `div_b`, `scl_hz`, `err` and `done` are all 0.
- R2: Let t = floor(fin_hz / (22 * target_hz)). If t is 0 or greater than 256, the search ends with `err`=1 and `div_a`=0, `div_b`=0, `scl_hz`=0.
- R3: Coarse values A = 0, 1, 2, 3 are tried in ascending order. For each A the fine count is b = ceil(fin_hz / (22 * target_hz * (A+1))). A candidate with b outside 1..64 is skipped, and a kept candidate reports `div_b` = b-1.
- R4: The frequency of a candidate is floor(fin_hz / (22 * (A+1) * (B+1))). A candidate whose frequency is above `target_hz` is discarded, and the reported `scl_hz` is never above the target when `err`=0.
- R5: A candidate's error is target_hz minus its frequency. A candidate replaces the current best only when its error is strictly smaller, so on equal error the smaller A is reported.
- R6: If t is within 1..256 but no candidate survives, the result is `div_a`=0, `div_b`=0, `scl_hz`=target_hz and `err`=0.
- R7: `done` is high for exactly one cycle per search. `div_a`, `div_b`, `scl_hz` and `err` change only in the cycle in which `done` is high.
- R8: A `start` pulse received while a search is running is ignored. It neither changes that search's result nor triggers a second `done`.
- R9: `done` rises at most 340 clock cycles after the cycle in which `start` is sampled.
- R10: A target of 0 Hz ends with `err`=1 and all divider outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a search, sampled only when idle |
| fin_hz | input | 32 | Input clock frequency in Hz |
| target_hz | input | 32 | Wanted bus clock frequency in Hz |
| div_a | output | 2 | Chosen coarse divider value |
| div_b | output | 6 | Chosen fine divider value |
| scl_hz | output | 32 | Resulting bus clock frequency in Hz |
| done | output | 1 | One-cycle pulse when the result is valid |
| err | output | 1 | The requested ratio is out of range |

## Verification
The bench builds the block with its default parameters: a 32-bit frequency width, a 2-bit coarse and a 6-bit fine field, and the fixed factor 22. With these defaults, small frequencies reach the exact t=256 edge and the ratio 256.5 in which every candidate is rejected. A 0xFFFFFFFF input clock exercises the 64-bit ceiling numerator and the full 32-bit quotient. Searches of realistic size show the equal-error case between A=0 and A=1, and a restart issued in mid-search checks that the engine keeps its latched operands.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_TDIV,
    S_BDIV,
    S_FDIV,
    S_NEXT,
    S_DONE
  } srch_state_t;
endpackage

// File: rtl/scl_div_divider.sv
module scl_div_divider #(
  parameter int NW = 64,
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic [QW-1:0] quo,
  output logic          fin
);
  localparam int XW = NW + QW;
  localparam int IW = $clog2(QW);

  logic [NW-1:0] rem_q;
  logic [NW-1:0] den_q;
  logic [IW-1:0] idx_q;
  logic          run_q;
  logic [XW-1:0] shifted;
  logic          fits;

  always_comb begin
    shifted = XW'(den_q) << idx_q;
    fits    = (XW'(rem_q) >= shifted);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      idx_q <= '0;
      run_q <= 1'b0;
      quo   <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !run_q) begin
        rem_q <= num;
        den_q <= den;
        idx_q <= IW'(QW - 1);
        quo   <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) rem_q <= rem_q - shifted[NW-1:0];
        quo[idx_q] <= fits;
        if (idx_q == '0) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  // R8
  go_idle_chk: assert property (@(posedge clk) disable iff (rst) go |-> !run_q);
  // R9
  fin_stop_chk: assert property (@(posedge clk) disable iff (rst) fin |-> !run_q);
endmodule

// File: rtl/scl_div_best.sv
module scl_div_best #(
  parameter int FW = 32,
  parameter int AW = 2,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [FW-1:0] init_f,
  input  logic          cand_vld,
  input  logic [AW-1:0] cand_a,
  input  logic [BW-1:0] cand_b,
  input  logic [FW-1:0] cand_f,
  input  logic [FW-1:0] cand_err,
  output logic [AW-1:0] best_a,
  output logic [BW-1:0] best_b,
  output logic [FW-1:0] best_f
);
  logic [FW-1:0] best_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      best_err <= '1;
      best_a   <= '0;
      best_b   <= '0;
      best_f   <= '0;
    end else if (init) begin
      best_err <= '1;
      best_a   <= '0;
      best_b   <= '0;
      best_f   <= init_f;
    end else if (cand_vld && (cand_err < best_err)) begin
      best_err <= cand_err;
      best_a   <= cand_a;
      best_b   <= cand_b;
      best_f   <= cand_f;
    end
  end

  // R5
  best_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !init |=> best_err <= $past(best_err));
  // R5
  tie_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && cand_vld && cand_err == best_err) |=> $stable(best_a));
endmodule

// File: rtl/scl_div_search.sv
module scl_div_search
  import scl_div_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int A_W    = 2,
  parameter int B_W    = 6,
  parameter int SCALE  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FREQ_W-1:0] fin_hz,
  input  logic [FREQ_W-1:0] target_hz,
  output logic [A_W-1:0]    div_a,
  output logic [B_W-1:0]    div_b,
  output logic [FREQ_W-1:0] scl_hz,
  output logic              done,
  output logic              err
);
  localparam int NW        = 2 * FREQ_W;
  localparam int NUM_A     = 1 << A_W;
  localparam int B_MAX     = 1 << B_W;
  localparam int T_MAX     = NUM_A * B_MAX;
  localparam int LAT_LIMIT = (2 * NUM_A + 1) * (FREQ_W + 4) + 16;
  localparam int LW        = $clog2(LAT_LIMIT + 2) + 1;

  srch_state_t       state;
  logic [FREQ_W-1:0] fin_q, tgt_q;
  logic [A_W-1:0]    a_idx;
  logic [B_W-1:0]    b_cand;
  logic              err_q;
  logic              dv_go;
  logic [NW-1:0]     dv_num, dv_den;
  logic [FREQ_W-1:0] dv_quo;
  logic              dv_fin;
  logic              bt_init, cand_vld;
  logic [A_W-1:0]    best_a;
  logic [B_W-1:0]    best_b;
  logic [FREQ_W-1:0] best_f;
  logic [LW-1:0]     lat_cnt;

  function automatic logic [NW-1:0] coarse_den(input logic [FREQ_W-1:0] tgt,
                                               input logic [A_W-1:0] a);
    return NW'(SCALE) * NW'(tgt) * (NW'(a) + NW'(1));
  endfunction

  scl_div_divider #(.NW(NW), .QW(FREQ_W)) u_div (
    .clk(clk), .rst(rst), .go(dv_go), .num(dv_num), .den(dv_den),
    .quo(dv_quo), .fin(dv_fin)
  );

  assign bt_init  = (state == S_TDIV) && dv_fin;
  assign cand_vld = (state == S_FDIV) && dv_fin && (dv_quo <= tgt_q);

  scl_div_best #(.FW(FREQ_W), .AW(A_W), .BW(B_W)) u_best (
    .clk(clk), .rst(rst), .init(bt_init), .init_f(tgt_q),
    .cand_vld(cand_vld), .cand_a(a_idx), .cand_b(b_cand),
    .cand_f(dv_quo), .cand_err(tgt_q - dv_quo),
    .best_a(best_a), .best_b(best_b), .best_f(best_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      fin_q  <= '0;
      tgt_q  <= '0;
      a_idx  <= '0;
      b_cand <= '0;
      err_q  <= 1'b0;
      dv_go  <= 1'b0;
      dv_num <= '0;
      dv_den <= '0;
      div_a  <= '0;
      div_b  <= '0;
      scl_hz <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      dv_go <= 1'b0;
      done  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fin_q  <= fin_hz;
          tgt_q  <= target_hz;
          err_q  <= 1'b0;
          dv_num <= NW'(fin_hz);
          dv_den <= NW'(SCALE) * NW'(target_hz);
          dv_go  <= 1'b1;
          state  <= S_TDIV;
        end
        S_TDIV: if (dv_fin) begin
          if (dv_quo == '0 || dv_quo > FREQ_W'(T_MAX)) begin
            err_q <= 1'b1;
            state <= S_DONE;
          end else begin
            a_idx  <= '0;
            dv_den <= coarse_den(tgt_q, '0);
            dv_num <= NW'(fin_q) + coarse_den(tgt_q, '0) - NW'(1);
            dv_go  <= 1'b1;
            state  <= S_BDIV;
          end
        end
        S_BDIV: if (dv_fin) begin
          if (dv_quo == '0 || dv_quo > FREQ_W'(B_MAX)) begin
            state <= S_NEXT;
          end else begin
            b_cand <= B_W'(dv_quo - 1'b1);
            dv_num <= NW'(fin_q);
            dv_den <= NW'(SCALE) * (NW'(a_idx) + NW'(1)) * NW'(dv_quo);
            dv_go  <= 1'b1;
            state  <= S_FDIV;
          end
        end
        S_FDIV: if (dv_fin) state <= S_NEXT;
        S_NEXT: begin
          if (a_idx == A_W'(NUM_A - 1)) begin
            state <= S_DONE;
          end else begin
            a_idx  <= a_idx + 1'b1;
            dv_den <= coarse_den(tgt_q, a_idx + 1'b1);
            dv_num <= NW'(fin_q) + coarse_den(tgt_q, a_idx + 1'b1) - NW'(1);
            dv_go  <= 1'b1;
            state  <= S_BDIV;
          end
        end
        S_DONE: begin
          div_a  <= err_q ? '0 : best_a;
          div_b  <= err_q ? '0 : best_b;
          scl_hz <= err_q ? '0 : best_f;
          err    <= err_q;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (state == S_IDLE) lat_cnt <= '0;
    else if (lat_cnt != '1) lat_cnt <= lat_cnt + 1'b1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(div_a) && $stable(div_b) && $stable(scl_hz) && $stable(err)));
  // R2
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (div_a == '0 && div_b == '0 && scl_hz == '0));
  // R4
  fscl_le_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (scl_hz <= tgt_q));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> ($stable(fin_q) && $stable(tgt_q)));
  // R9
  lat_bound_chk: assert property (@(posedge clk) disable iff (rst)
    lat_cnt <= LW'(LAT_LIMIT));
endmodule

// File: tb/scl_div_search_test.sv
`timescale 1ns/1ps
module scl_div_search_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] fin_hz = '0, target_hz = '0;
  logic [1:0]  div_a;
  logic [5:0]  div_b;
  logic [31:0] scl_hz;
  logic        done, err;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  scl_div_search uut (
    .clk(clk), .rst(rst), .start(start), .fin_hz(fin_hz), .target_hz(target_hz),
    .div_a(div_a), .div_b(div_b), .scl_hz(scl_hz), .done(done), .err(err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint unsigned f, input longint unsigned t,
                       output bit e, output int a, output int b, output longint unsigned fr);
    longint unsigned tt, best, d, bb, act;
    e = 0; a = 0; b = 0; fr = t;
    if (t == 0) begin e = 1; fr = 0; return; end
    tt = f / (22 * t);
    if (tt == 0 || tt > 256) begin e = 1; fr = 0; return; end
    best = 64'hFFFF_FFFF;
    for (int ai = 0; ai < 4; ai++) begin
      d  = 22 * t * (ai + 1);
      bb = (f + d - 1) / d;
      if (bb < 1 || bb > 64) continue;
      act = f / (22 * (ai + 1) * bb);
      if (act > t) continue;
      if (t - act < best) begin
        best = t - act; a = ai; b = int'(bb) - 1; fr = act;
      end
    end
  endtask

  task automatic run(input logic [31:0] f, input logic [31:0] t, output int lat);
    @(negedge clk);
    fin_hz = f; target_hz = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_check(input string tag, input logic [31:0] f, input logic [31:0] t);
    int lat; bit e; int a, b; longint unsigned fr;
    model(f, t, e, a, b, fr);
    run(f, t, lat);
    chk({tag, " R9 latency<=340"}, (lat <= 340) ? 1 : 0, 1);
    chk({tag, " err"}, err, e);
    chk({tag, " div_a R3"}, div_a, a);
    chk({tag, " div_b R3"}, div_b, b);
    chk({tag, " scl_hz R4"}, scl_hz, fr);
  endtask

  task automatic t_reset();
    chk("R1 div_a", div_a, 0);
    chk("R1 div_b", div_b, 0);
    chk("R1 scl_hz", scl_hz, 0);
    chk("R1 err", err, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_nominal();
    run_check("R3 100MHz/100kHz", 100_000_000, 100_000);
    chk("R5 tie keeps A=0", div_a, 0);
    chk("R5 fine value", div_b, 45);
    chk("R4 freq", scl_hz, 98814);
    run_check("R4 111MHz/400kHz", 111_111_111, 400_000);
    run_check("R3 33MHz/10kHz", 33_333_333, 10_000);
  endtask

  task automatic t_errors();
    run_check("R2 t=0", 1000, 100);
    chk("R2 err flag", err, 1);
    run_check("R2 t>256", 100_000_000, 1000);
    chk("R2 err flag high", err, 1);
    run_check("R10 zero target", 50_000_000, 0);
    chk("R10 err flag", err, 1);
  endtask

  task automatic t_edges();
    run_check("R6 no candidate", 5643, 1);
    chk("R6 div_a", div_a, 0);
    chk("R6 div_b", div_b, 0);
    chk("R6 scl_hz", scl_hz, 1);
    chk("R6 err", err, 0);
    run_check("R3 t=256 exact", 5632, 1);
    chk("R3 A=3", div_a, 3);
    chk("R3 B=63", div_b, 63);
    run_check("R4 full-width fin", 32'hFFFF_FFFF, 100_000_000);
  endtask

  task automatic t_pulse_hold();
    logic [1:0] a0; logic [5:0] b0; logic [31:0] f0;
    int lat;
    run(24_000_000, 100_000, lat);
    a0 = div_a; b0 = div_b; f0 = scl_hz;
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    repeat (20) @(negedge clk);
    chk("R7 div_a hold", div_a, a0);
    chk("R7 div_b hold", div_b, b0);
    chk("R7 scl_hz hold", scl_hz, f0);
  endtask

  task automatic t_busy_start();
    bit e; int a, b; longint unsigned fr; int lat; int extra;
    model(48_000_000, 100_000, e, a, b, fr);
    @(negedge clk);
    fin_hz = 48_000_000; target_hz = 100_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    fin_hz = 1000; target_hz = 100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fin_hz = '0; target_hz = '0;
    lat = 0;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    chk("R8 err", err, e);
    chk("R8 div_a", div_a, a);
    chk("R8 div_b", div_b, b);
    chk("R8 scl_hz", scl_hz, fr);
    extra = 0;
    repeat (400) begin @(negedge clk); if (done) extra++; end
    chk("R8 no second done", extra, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_errors();
    t_edges();
    t_pulse_hold();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule